// File: doc/BRIEF.md
# Arm Submodule Insertion Selector

This block picks which submodules of one converter arm are inserted in the coming control period, so that the capacitor voltages of the arm stay balanced. It takes one voltage sample for each of the N submodule capacitors, one bit for the sign of the arm current, and the number of submodules to insert. It sorts the samples in ascending order with an in-place pivot-partition sort, and each value keeps its submodule index while it is sorted. The block then marks the inserted submodules in an N-bit mask.

When the arm current charges the capacitors, the least-charged submodules are inserted. When it discharges them, the most-charged submodules are inserted. A converter leg uses two instances, one for each arm. The lower arm is given the count N minus the upper count.

A one-cycle start pulse loads the samples and begins a control period. The sort runs one compare step per clock and keeps its pending subranges on an explicit stack, so no recursion is needed. At the end of the period a one-cycle done pulse appears together with a newly registered mask. That mask holds until the next done pulse.

Top module: `arm_insert_sel`

## Requirements
- R1: When cur_neg_i is 0 (arm current positive or zero), mask_o bit k is 1 exactly when submodule k is among the count_i submodules with the lowest voltages. Submodule k occupies volt_i[k*VW +: VW], and mask bit k refers to the same submodule.
- R2: When cur_neg_i is 1 (arm current negative), mask_o bit k is 1 exactly when submodule k is among the count_i submodules with the highest voltages.
- R3: When voltages are equal, the submodule with the lower index wins the place, in both current directions.
- R4: A count of 0 gives an all-zero mask. A count above N is treated as N and gives an all-ones mask.
- R5: done_o is high for exactly one cycle. mask_o changes on the same edge, and its number of ones equals the count, saturated as in R4.
- R6: Between done pulses, mask_o holds its value, and changes on volt_i, count_i or cur_neg_i have no effect without an accepted start.
- R7: A start_i pulse that arrives while busy_o is high is ignored. The result then reflects the inputs present at the accepted start.
- R8: busy_o is high in the cycle after an accepted start. done_o follows the start within 2*N*N+8 cycles.
- R9: After reset, mask_o is all zeros and done_o and busy_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse that starts a control period; accepted only when idle |
| volt_i | input | N*VW | Capacitor voltages; submodule k at bits [k*VW +: VW] |
| cur_neg_i | input | 1 | 1 when the arm current is negative (discharging) |
| count_i | input | $clog2(N+1) | Number of submodules to insert |
| busy_o | output | 1 | A sort is in progress |
| done_o | output | 1 | One-cycle pulse; mask_o has just been updated |
| mask_o | output | N | Insertion mask; bit k set means submodule k is inserted |

## Verification
The bench sweeps every count from 0 to N+1 in both current directions, using voltage patterns with many exact ties as well as wide random values, and compares each mask with a rank computed in the bench. A sorter that mishandles equal keys would select the wrong one of two equal submodules, or would stall with its scan index stuck past the subrange. A wrong direction decode would mirror the selection. Missing saturation would give a truncated mask for a count of N+1.

Further cases cover the two reference arm patterns, a start pulse sent in the middle of a sort, and input changes between periods. A design that restarts on a busy start would report the second pattern. A mask that is not held would follow the inputs.

// File: rtl/arm_sel_pkg.sv
package arm_sel_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_POP  = 2'd2
  } sort_st_e;
endpackage

// File: rtl/range_stack.sv
module range_stack #(
  parameter int DEPTH = 5,
  parameter int EW    = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          pop_i,
  input  logic          push_a_i,
  input  logic [EW-1:0] a_i,
  input  logic          push_b_i,
  input  logic [EW-1:0] b_i,
  output logic          empty_o,
  output logic [EW-1:0] top_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int SLOTS = 1 << SPW;

  logic [EW-1:0]  mem [SLOTS];
  logic [SPW-1:0] sp;
  logic [SPW-1:0] sp_b;

  assign sp_b    = push_a_i ? sp + SPW'(1) : sp;
  assign empty_o = (sp == '0);
  assign top_o   = mem[sp - SPW'(1)];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sp <= '0;
    else if (clr_i)   sp <= '0;
    else if (pop_i)   sp <= sp - SPW'(1);
    else              sp <= sp + SPW'(push_a_i) + SPW'(push_b_i);
  end

  always_ff @(posedge clk_i) begin
    if (push_a_i) mem[sp]   <= a_i;
    if (push_b_i) mem[sp_b] <= b_i;
  end
endmodule

// File: rtl/pivot_sorter.sv
module pivot_sorter
  import arm_sel_pkg::*;
#(
  parameter int N  = 5,
  parameter int VW = 12,
  localparam int IW = $clog2(N),
  localparam int PW = $clog2(N + 1),
  localparam int KW = VW + IW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [N*VW-1:0] volt_i,
  input  logic          desc_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [N*IW-1:0] tags_o
);
  sort_st_e      st;
  logic [KW-1:0] key [N];
  logic [IW-1:0] tag [N];
  logic [PW-1:0] lo, hi, i, j;

  logic          i_ok, i_adv, j_dec, part_end;
  logic [KW-1:0] piv, ki, kj;
  logic          push_a, push_b, pop, empty;
  logic [2*PW-1:0] top;

  assign piv      = key[lo];
  assign i_ok     = (i <= hi);
  assign ki       = key[i_ok ? i : hi];
  assign kj       = key[j];
  assign i_adv    = i_ok && (piv > ki);   // keys are unique, so >= equals >
  assign j_dec    = (piv < kj);
  assign part_end = (st == ST_SCAN) && !i_adv && !j_dec && !(i < j);
  assign push_a   = part_end && (j > lo + PW'(1));
  assign push_b   = part_end && (hi > j + PW'(1));
  assign pop      = (st == ST_POP) && !empty;
  assign busy_o   = (st != ST_IDLE);

  range_stack #(.DEPTH(N), .EW(2*PW)) u_stack (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (load_i),
    .pop_i   (pop),
    .push_a_i(push_a),
    .a_i     ({lo, j - PW'(1)}),
    .push_b_i(push_b),
    .b_i     ({j + PW'(1), hi}),
    .empty_o (empty),
    .top_o   (top)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st    <= ST_IDLE;
      fin_o <= 1'b0;
      lo    <= '0;
      hi    <= '0;
      i     <= '0;
      j     <= '0;
    end else begin
      fin_o <= 1'b0;
      unique case (st)
        ST_IDLE: if (load_i) begin
          lo <= '0;
          hi <= PW'(N - 1);
          i  <= PW'(1);
          j  <= PW'(N - 1);
          st <= ST_SCAN;
        end
        ST_SCAN: begin
          if (i_adv)       i <= i + PW'(1);
          else if (j_dec)  j <= j - PW'(1);
          else if (!(i < j)) st <= ST_POP;
        end
        ST_POP: begin
          if (empty) begin
            st    <= ST_IDLE;
            fin_o <= 1'b1;
          end else begin
            lo <= top[2*PW-1:PW];
            hi <= top[PW-1:0];
            i  <= top[2*PW-1:PW] + PW'(1);
            j  <= top[PW-1:0];
            st <= ST_SCAN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // key and tag array: load, then swaps during scan
  always_ff @(posedge clk_i) begin
    if (st == ST_IDLE && load_i) begin
      for (int k = 0; k < N; k++) begin
        key[k] <= {volt_i[k*VW +: VW], desc_i ? ~IW'(k) : IW'(k)};
        tag[k] <= IW'(k);
      end
    end else if (st == ST_SCAN && !i_adv && !j_dec) begin
      if (i < j) begin
        key[i] <= key[j];  key[j] <= key[i];
        tag[i] <= tag[j];  tag[j] <= tag[i];
      end else begin
        key[lo] <= key[j]; key[j] <= key[lo];
        tag[lo] <= tag[j]; tag[j] <= tag[lo];
      end
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_tags
    assign tags_o[g*IW +: IW] = tag[g];
  end
endmodule

// File: rtl/insert_mask.sv
module insert_mask #(
  parameter int N = 5,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic [N*IW-1:0] tags_i,
  input  logic [CW-1:0]   cnt_i,
  input  logic            desc_i,
  output logic [N-1:0]    mask_o
);
  always_comb begin
    mask_o = '0;
    for (int r = 0; r < N; r++) begin
      // rank r in ascending order; discharge takes the top of the order
      if (desc_i ? (r + int'(cnt_i) >= N) : (r < int'(cnt_i)))
        mask_o[tags_i[r*IW +: IW]] = 1'b1;
    end
  end
endmodule

// File: rtl/arm_insert_sel.sv
module arm_insert_sel #(
  parameter int N  = 5,
  parameter int VW = 12,
  localparam int IW = $clog2(N),
  localparam int CW = $clog2(N + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N*VW-1:0] volt_i,
  input  logic            cur_neg_i,
  input  logic [CW-1:0]   count_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [N-1:0]    mask_o
);
  logic            accept, fin;
  logic [CW-1:0]   cnt_q;
  logic            desc_q;
  logic [N*IW-1:0] tags;
  logic [N-1:0]    mask_w;

  assign accept = start_i && !busy_o;

  pivot_sorter #(.N(N), .VW(VW)) u_sort (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .volt_i(volt_i),
    .desc_i(cur_neg_i),
    .busy_o(busy_o),
    .fin_o (fin),
    .tags_o(tags)
  );

  insert_mask #(.N(N)) u_mask (
    .tags_i(tags),
    .cnt_i (cnt_q),
    .desc_i(desc_q),
    .mask_o(mask_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      desc_q <= 1'b0;
      mask_o <= '0;
      done_o <= 1'b0;
    end else begin
      if (accept) begin
        cnt_q  <= (int'(count_i) > N) ? CW'(N) : count_i;
        desc_q <= cur_neg_i;
      end
      done_o <= fin;
      if (fin) mask_o <= mask_w;
    end
  end
endmodule

// File: rtl/arm_insert_sel_chk.sv
module arm_insert_sel_chk #(
  parameter int N = 5,
  localparam int CW = $clog2(N + 1),
  localparam int LIM = 2 * N * N + 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [N-1:0]  mask_o,
  input logic [CW-1:0] cnt_q
);
  logic [15:0] lat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  lat <= '0;
    else if (start_i && !busy_o)  lat <= '0;
    else if (busy_o && lat != 16'hffff) lat <= lat + 16'd1;
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  mask_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($countones(mask_o) == int'(cnt_q)));
  // R6
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(mask_o));
  // R7
  busy_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(cnt_q));
  // R8
  busy_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o);
  // R8
  sort_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (int'(lat) <= LIM));
endmodule

bind arm_insert_sel arm_insert_sel_chk #(.N(N)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .busy_o (busy_o),
  .done_o (done_o),
  .mask_o (mask_o),
  .cnt_q  (cnt_q)
);

// File: tb/arm_insert_sel_tb.sv
module arm_insert_sel_tb;
  localparam int N  = 5;
  localparam int VW = 12;
  localparam int CW = $clog2(N + 1);
  localparam int LIM = 2 * N * N + 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [N*VW-1:0] volt_i = '0;
  logic            cur_neg_i = 1'b0;
  logic [CW-1:0]   count_i = '0;
  logic            busy_o, done_o;
  logic [N-1:0]    mask_o;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  logic [31:0] seed = 32'h1234_5678;

  arm_insert_sel #(.N(N), .VW(VW)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .volt_i(volt_i),
    .cur_neg_i(cur_neg_i), .count_i(count_i), .busy_o(busy_o),
    .done_o(done_o), .mask_o(mask_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // rank-based reference: lower voltage (or higher when discharging) first, ties to lower index
  function automatic logic [N-1:0] ref_mask(input logic [N*VW-1:0] v, input int cnt,
                                            input bit neg);
    logic [N-1:0] m = '0;
    int c = (cnt > N) ? N : cnt;
    for (int k = 0; k < N; k++) begin
      int rank = 0;
      for (int o = 0; o < N; o++) begin
        int vo = int'(v[o*VW +: VW]);
        int vk = int'(v[k*VW +: VW]);
        if (o != k) begin
          if (neg ? (vo > vk) : (vo < vk)) rank++;
          else if (vo == vk && o < k) rank++;
        end
      end
      if (rank < c) m[k] = 1'b1;
    end
    return m;
  endfunction

  task automatic wait_done(input string req, output logic [N-1:0] got);
    int lat = 1;
    while (!done_o && lat < 400) begin
      @(negedge clk_i);
      lat++;
    end
    chk(done_o == 1'b1, {req, " R8 done"}, 32'(done_o), 32'd1);
    chk(lat <= LIM, "R8 latency", 32'(lat), 32'(LIM));
    got = mask_o;
    @(negedge clk_i);
    chk(done_o == 1'b0, "R5 pulse width", 32'(done_o), 32'd0);
    chk(mask_o == got, "R6 mask held", 32'(mask_o), 32'(got));
  endtask

  task automatic run(input logic [N*VW-1:0] v, input int cnt, input bit neg,
                     input string req, output logic [N-1:0] got);
    volt_i    = v;
    count_i   = CW'(cnt);
    cur_neg_i = neg;
    start_i   = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R8 busy after start", 32'(busy_o), 32'd1);
    wait_done(req, got);
  endtask

  function automatic logic [N*VW-1:0] pack5(input int a, input int b, input int c,
                                            input int d, input int e);
    return {VW'(e), VW'(d), VW'(c), VW'(b), VW'(a)};
  endfunction

  initial begin
    logic [N-1:0] got, exp, held;
    logic [N*VW-1:0] v, v2;

    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(mask_o == '0, "R9 mask", 32'(mask_o), 32'd0);
    chk(done_o == 1'b0, "R9 done", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R9 busy", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 upper-arm example
    run(pack5(630, 610, 650, 640, 620), 2, 1'b0, "R1", got);
    chk(got == 5'b10010, "R1 upper arm example", 32'(got), 32'h12);
    // R2 lower-arm example
    run(pack5(690, 660, 700, 680, 670), 3, 1'b1, "R2", got);
    chk(got == 5'b01101, "R2 lower arm example", 32'(got), 32'h0d);

    // R3 all equal: lowest indices win in both directions
    run(pack5(500, 500, 500, 500, 500), 2, 1'b0, "R3", got);
    chk(got == 5'b00011, "R3 ties charging", 32'(got), 32'h03);
    run(pack5(500, 500, 500, 500, 500), 3, 1'b1, "R3", got);
    chk(got == 5'b00111, "R3 ties discharging", 32'(got), 32'h07);

    // R4 saturation and zero
    run(pack5(10, 20, 30, 40, 50), N + 1, 1'b0, "R4", got);
    chk(got == 5'b11111, "R4 count above N", 32'(got), 32'h1f);
    run(pack5(10, 20, 30, 40, 50), 0, 1'b1, "R4", got);
    chk(got == 5'b00000, "R4 count zero", 32'(got), 32'h00);

    // R1 R2 R3 R4 sweep: tie-heavy and wide patterns, every count, both directions
    for (int p = 0; p < 12; p++) begin
      for (int k = 0; k < N; k++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        v[k*VW +: VW] = (p < 6) ? VW'(seed[17:16]) : VW'(seed[27:16]);
      end
      for (int neg = 0; neg < 2; neg++) begin
        for (int c = 0; c <= N + 1; c++) begin
          run(v, c, neg[0], "sweep", got);
          exp = ref_mask(v, c, neg[0]);
          chk(got == exp, neg ? "R2 R3 R4 sweep" : "R1 R3 R4 sweep", 32'(got), 32'(exp));
        end
      end
    end

    // R7 start while busy is ignored
    v  = pack5(100, 400, 300, 200, 500);
    v2 = pack5(900, 100, 800, 200, 700);
    volt_i = v; count_i = CW'(2); cur_neg_i = 1'b0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    @(negedge clk_i);
    volt_i = v2; count_i = CW'(4); cur_neg_i = 1'b1; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    wait_done("R7", got);
    exp = ref_mask(v, 2, 1'b0);
    chk(got == exp, "R7 busy start ignored", 32'(got), 32'(exp));
    chk(busy_o == 1'b0, "R7 no restart", 32'(busy_o), 32'd0);

    // R6 input changes without start do not touch the mask
    held = mask_o;
    volt_i = v2; count_i = CW'(5); cur_neg_i = 1'b1;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk_i);
      if (done_o || mask_o != held) break;
    end
    chk(mask_o == held, "R6 mask held without start", 32'(mask_o), 32'(held));
    chk(done_o == 1'b0, "R6 no done without start", 32'(done_o), 32'd0);
    chk(busy_o == 1'b0, "R6 stays idle", 32'(busy_o), 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule